// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Matcher

This block watches the current BCD time and date and compares it against two programmable alarm sets. The comparison runs only in the clock cycle where the once-per-second update pulse is high. Alarm A covers seconds, minutes, hours and a day-or-date field. Alarm B covers minutes, hours and a day-or-date field. Alarm B has no seconds field and only matches when the current seconds read 00.

Each alarm field carries its own mask bit. A masked field is left out of the comparison, so software picks the repeat rate by choosing which fields to mask. A match raises a sticky flag for that alarm. Software clears a flag by writing 0 to it; writing 1 leaves it as it is. An active-low interrupt output is asserted while interrupt mode is selected and at least one flag is set whose enable is set. When interrupt mode is off, the square-wave logic outside this block owns the shared pin. The flags are still raised in that mode.

All setup goes through a simple byte write port. The time inputs come straight from the timekeeping counters. The hours field is compared as raw register bits, including the 12/24 select and the AM/PM bit.

Top module: `tod_alarm_unit`

## Requirements
- R1: A comparison is made only in a cycle with `sec_tick` high. Without a tick, the flags do not change, even when the time inputs equal the alarm settings.
- R2: With no field masked, Alarm A's flag is set when all of these match: seconds (bits 6:0), minutes (bits 6:0), hours (bits 6:0, including bit 6 = 12-hour select and bit 5 = PM), and the day/date value. The flag becomes visible on the clock edge that samples the tick.
- R3: Bit 7 of each alarm field register is its mask; 1 removes that field from the comparison. With all four Alarm A masks set, Alarm A's flag is set on every tick.
- R4: Alarm B only matches when the current seconds are 00. With all its masks set, it fires once per minute. With only minutes unmasked, it fires at second 00 of the matching minute.
- R5: In a day/date alarm register, bit 6 = 1 compares bits 5:0 with the weekday input, and bit 6 = 0 compares them with the day of month.
- R6: A match sets the alarm's flag whatever the interrupt mode is.
- R7: Writing the status register (address 8) with bit 0 = 0 clears flag A and with bit 1 = 0 clears flag B. A 1 bit has no effect. If a match and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: `irq_n` is low exactly when interrupt mode is 1 and some flag is set with its enable at 1. It stays low until that flag is cleared.
- R9: After a synchronous reset: interrupt mode is 1, both enables are 0, both flags are 0, all alarm fields are 0, and `irq_n` is high.
- R10: Register map for writes:
  - 0–3: Alarm A seconds, minutes, hours, day/date.
  - 4–6: Alarm B minutes, hours, day/date.
  - 7: control, with bit 0 = enable A, bit 1 = enable B, bit 2 = interrupt mode.
  - 8: status.
  - A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | Once-per-second update pulse, one cycle wide |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours register bits 6:0 (12/24, AM/PM or tens, BCD) |
| now_wday | input | 3 | Current weekday 1–7 |
| now_mday | input | 6 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| flag_a | output | 1 | Sticky Alarm A flag |
| flag_b | output | 1 | Sticky Alarm B flag |
| irq_mode | output | 1 | 1 = pin used as interrupt, 0 = square wave |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
- Flag timing: a flag is registered on the edge that samples the tick, so it can be read at the falling edge that follows. `irq_n` is decoded without a register from the flags and control bits, so it changes on that same edge.
- Write timing: a register write takes effect on the first rising edge, so a clear or a control change shows at the next falling edge.
- Bench procedure: every stimulus is driven at a falling edge and held across exactly one rising edge. The outputs are then sampled at the following falling edge and compared against a match computed from the programmed fields.
- Sweeps: seconds, minutes, weekdays and dates are swept with the flags cleared between points.

// File: rtl/tod_alarm_pkg.sv
// Package: shared constants and types for the time-of-day alarm matcher.
// Assumes 8-bit alarm registers with the mask in bit 7 and the day/date
// select in bit 6 of the day/date register.
package tod_alarm_pkg;
    localparam int NUM_ALARMS  = 2;
    localparam int REG_W       = 8;
    localparam int MASK_BIT    = 7;
    localparam int DAYSEL_BIT  = 6;
    localparam int VAL_W       = 7;   // compared width for sec/min/hour
    localparam int DD_W        = 6;   // compared width for day/date

    // write addresses
    localparam int ADR_A_SEC   = 0;
    localparam int ADR_A_MIN   = 1;
    localparam int ADR_A_HOUR  = 2;
    localparam int ADR_A_DD    = 3;
    localparam int ADR_B_MIN   = 4;
    localparam int ADR_B_HOUR  = 5;
    localparam int ADR_B_DD    = 6;
    localparam int ADR_CTRL    = 7;
    localparam int ADR_STATUS  = 8;

    // control register bit positions
    localparam int CTL_EN_A    = 0;
    localparam int CTL_EN_B    = 1;
    localparam int CTL_MODE    = 2;

    typedef struct packed {
        logic [REG_W-1:0] sec;
        logic [REG_W-1:0] min;
        logic [REG_W-1:0] hour;
        logic [REG_W-1:0] dd;
    } alarm_set_t;

    typedef struct packed {
        logic [VAL_W-1:0] sec;
        logic [VAL_W-1:0] min;
        logic [VAL_W-1:0] hour;
        logic [DD_W-1:0]  wday;
        logic [DD_W-1:0]  mday;
    } now_t;
endpackage

// File: rtl/alarm_regfile.sv
// Module: alarm_regfile
// Holds both alarm register sets and the control bits, and decodes the
// write port. Alarm B has no seconds register: its seconds field reads
// as a constant unmasked 00, so it only matches at second 00.
// Assumes one write per cycle; writes to unmapped addresses are dropped.
module alarm_regfile
    import tod_alarm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    output alarm_set_t         alm [NUM_ALARMS],
    output logic [NUM_ALARMS-1:0] enables,
    output logic               mode_irq,
    output logic               clr_we,
    output logic [NUM_ALARMS-1:0] clr_keep
);
    logic [REG_W-1:0] a_sec, a_min, a_hour, a_dd;
    logic [REG_W-1:0] b_min, b_hour, b_dd;
    logic unused_wr_bits;

    // Register writes and reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sec    <= '0;
            a_min    <= '0;
            a_hour   <= '0;
            a_dd     <= '0;
            b_min    <= '0;
            b_hour   <= '0;
            b_dd     <= '0;
            enables  <= '0;
            mode_irq <= 1'b1;
        end else if (wr_en) begin
            case (int'(wr_addr))
                ADR_A_SEC:  a_sec  <= wr_data;
                ADR_A_MIN:  a_min  <= wr_data;
                ADR_A_HOUR: a_hour <= wr_data;
                ADR_A_DD:   a_dd   <= wr_data;
                ADR_B_MIN:  b_min  <= wr_data;
                ADR_B_HOUR: b_hour <= wr_data;
                ADR_B_DD:   b_dd   <= wr_data;
                ADR_CTRL: begin
                    enables[0] <= wr_data[CTL_EN_A];
                    enables[1] <= wr_data[CTL_EN_B];
                    mode_irq   <= wr_data[CTL_MODE];
                end
                default: ;
            endcase
        end
    end

    // Present the register sets in a uniform shape to the comparators.
    always_comb begin
        alm[0] = '{sec: a_sec, min: a_min, hour: a_hour, dd: a_dd};
        alm[1] = '{sec: '0,    min: b_min, hour: b_hour, dd: b_dd};
    end

    // Status write strobe: a 0 bit clears the matching flag.
    always_comb begin
        clr_we   = wr_en && (int'(wr_addr) == ADR_STATUS);
        clr_keep = wr_data[NUM_ALARMS-1:0];
    end

    assign unused_wr_bits = ^wr_data[REG_W-1:CTL_MODE+1];

    AST_RESET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mode_irq && enables == '0)) else $error("reset state"); // R9
endmodule

// File: rtl/alarm_compare.sv
// Module: alarm_compare
// Purely combinational field comparator for one alarm set. Each field
// whose mask bit is 0 must equal the current time; the day/date field
// compares against weekday or day of month by its select bit. Hours are
// compared as raw register bits.
module alarm_compare
    import tod_alarm_pkg::*;
(
    input  alarm_set_t alm,
    input  now_t       now,
    output logic       hit
);
    logic sec_ok, min_ok, hour_ok, dd_ok;
    logic [DD_W-1:0] dd_now;

    // Per-field match with mask override.
    always_comb begin
        sec_ok  = alm.sec[MASK_BIT]  || (alm.sec[VAL_W-1:0]  == now.sec);
        min_ok  = alm.min[MASK_BIT]  || (alm.min[VAL_W-1:0]  == now.min);
        hour_ok = alm.hour[MASK_BIT] || (alm.hour[VAL_W-1:0] == now.hour);
        dd_now  = alm.dd[DAYSEL_BIT] ? now.wday : now.mday;
        dd_ok   = alm.dd[MASK_BIT]   || (alm.dd[DD_W-1:0]    == dd_now);
        hit     = sec_ok && min_ok && hour_ok && dd_ok;
    end
endmodule

// File: rtl/alarm_flags.sv
// Module: alarm_flags
// Sticky per-alarm flags and the active-low interrupt decode. A match on
// the update pulse sets a flag; a status write with a 0 bit clears it,
// and a set in the same cycle wins over the clear.
module alarm_flags
    import tod_alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [NUM_ALARMS-1:0] hit,
    input  logic                  clr_we,
    input  logic [NUM_ALARMS-1:0] clr_keep,
    input  logic [NUM_ALARMS-1:0] enables,
    input  logic                  mode_irq,
    output logic [NUM_ALARMS-1:0] flags,
    output logic                  irq_n
);
    genvar g;
    generate
        for (g = 0; g < NUM_ALARMS; g++) begin : g_flag
            logic set_now, clr_now;
            assign set_now = tick && hit[g];
            assign clr_now = clr_we && !clr_keep[g];

            // One sticky flag: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)       flags[g] <= 1'b0;
                else if (set_now) flags[g] <= 1'b1;
                else if (clr_now) flags[g] <= 1'b0;
            end

            AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && hit[g]) |=> flags[g]) else $error("match lost"); // R2
            AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flags[g]) |-> $past(tick)) else $error("untimed set"); // R1
            AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flags[g]) |-> $past(clr_we && !clr_keep[g])) else $error("flag lost"); // R7
        end
    endgenerate

    // Interrupt decode from flags, enables and mode.
    always_comb begin
        irq_n = !(mode_irq && |(flags & enables));
    end
endmodule

// File: rtl/tod_alarm_unit.sv
// Module: tod_alarm_unit (top)
// Two masked time-of-day alarms with sticky flags and an active-low
// interrupt. Assumes time inputs are stable in the cycle sec_tick is high.
module tod_alarm_unit
    import tod_alarm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [6:0]        now_sec,
    input  logic [6:0]        now_min,
    input  logic [6:0]        now_hour,
    input  logic [2:0]        now_wday,
    input  logic [5:0]        now_mday,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              flag_a,
    output logic              flag_b,
    output logic              irq_mode,
    output logic              irq_n
);
    alarm_set_t            alm [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] enables, clr_keep, hit, flags;
    logic                  clr_we;
    now_t                  now;

    // Gather the time inputs into one bundle.
    always_comb begin
        now = '{sec: now_sec, min: now_min, hour: now_hour,
                wday: {{(DD_W-3){1'b0}}, now_wday}, mday: now_mday};
    end

    alarm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alm(alm), .enables(enables),
        .mode_irq(irq_mode), .clr_we(clr_we), .clr_keep(clr_keep)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_ALARMS; g++) begin : g_cmp
            alarm_compare u_cmp (.alm(alm[g]), .now(now), .hit(hit[g]));
        end
    endgenerate

    alarm_flags u_flags (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .hit(hit),
        .clr_we(clr_we), .clr_keep(clr_keep), .enables(enables),
        .mode_irq(irq_mode), .flags(flags), .irq_n(irq_n)
    );

    assign flag_a = flags[0];
    assign flag_b = flags[1];

    AST_B_AT_ZERO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_b) |-> $past(now_sec == 7'h00)) else $error("B off-minute"); // R4
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !wr_en) |=> !irq_n) else $error("irq dropped"); // R8
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_n && !flag_a && !flag_b)) else $error("reset"); // R9
endmodule

// File: tb/tod_alarm_unit_tb.sv
module tod_alarm_unit_tb_top;
    logic clk = 0, rst_n = 0, sec_tick = 0, wr_en = 0;
    logic [6:0] now_sec = 0, now_min = 0, now_hour = 0;
    logic [2:0] now_wday = 1;
    logic [5:0] now_mday = 1;
    logic [3:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic flag_a, flag_b, irq_mode, irq_n;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    tod_alarm_unit dut_i (.*);

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, clock once, release at next negedge.
    task automatic step(input logic t, input logic we, input int a, input logic [7:0] d);
        sec_tick = t; wr_en = we; wr_addr = 4'(a); wr_data = d;
        @(posedge clk); @(negedge clk);
        sec_tick = 0; wr_en = 0;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        step(0, 1, a, d);
    endtask

    task automatic set_now(input int s, input int m, input logic [6:0] h,
                           input int wd, input int md);
        now_sec = bcd(s)[6:0]; now_min = bcd(m)[6:0]; now_hour = h;
        now_wday = 3'(wd); now_mday = bcd(md)[5:0];
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R9: reset state
        chk(irq_n, 1, "R9 irq_n"); chk(flag_a, 0, "R9 flag_a");
        chk(flag_b, 0, "R9 flag_b"); chk(irq_mode, 1, "R9 mode");

        // R3: all Alarm A fields masked -> every tick
        for (int i = 0; i < 4; i++) wr(i, 8'h80);
        for (int s = 0; s < 60; s++) begin
            set_now(s, 7, 7'h12, 2, 9);
            step(1, 0, 0, 0);
            chk(flag_a, 1, "R3 all masked");
            wr(8, 8'h00);
        end

        // R3: seconds only unmasked, target 25
        wr(0, bcd(25));
        for (int s = 0; s < 60; s++) begin
            set_now(s, 3, 7'h05, 4, 17);
            step(1, 0, 0, 0);
            chk(flag_a, s == 25, "R3 seconds match");
            wr(8, 8'h00);
        end

        // R1: matching time without tick leaves flag clear
        set_now(25, 3, 7'h05, 4, 17);
        step(0, 0, 0, 0); step(0, 0, 0, 0);
        chk(flag_a, 0, "R1 no tick");

        // R2: exact match, 12-hour PM 11 raw hour bits 0x71, date 20
        wr(0, bcd(30)); wr(1, bcd(45)); wr(2, 8'h71); wr(3, bcd(20));
        begin
            logic [6:0] hrs [4] = '{7'h71, 7'h51, 7'h11, 7'h31};
            for (int k = 0; k < 4; k++) begin
                for (int mm = 44; mm < 47; mm++) begin
                    set_now(30, mm, hrs[k], 6, 20);
                    step(1, 0, 0, 0);
                    chk(flag_a, (k == 0) && (mm == 45), "R2 exact match");
                    wr(8, 8'h00);
                end
            end
        end
        set_now(30, 45, 7'h71, 6, 21); step(1, 0, 0, 0);
        chk(flag_a, 0, "R2 date mismatch"); wr(8, 8'h00);

        // R5: weekday select (bit6=1) value 3, time fields masked
        wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h43);
        for (int wd = 1; wd <= 7; wd++) begin
            set_now(10, 10, 7'h10, wd, 3 + wd);
            step(1, 0, 0, 0);
            chk(flag_a, wd == 3, "R5 weekday");
            wr(8, 8'h00);
        end
        // R5: date select (bit6=0) value 15
        wr(3, bcd(15));
        for (int md = 1; md <= 31; md++) begin
            set_now(10, 10, 7'h10, 3, md);
            step(1, 0, 0, 0);
            chk(flag_a, md == 15, "R5 date");
            wr(8, 8'h00);
        end

        // R4: Alarm B all masked -> only at second 00
        wr(4, 8'h80); wr(5, 8'h80); wr(6, 8'h80);
        for (int s = 0; s < 60; s++) begin
            set_now(s, 20, 7'h08, 1, 1);
            step(1, 0, 0, 0);
            chk(flag_b, s == 0, "R4 once per minute");
            wr(8, 8'h00);
        end
        // R4: minutes unmasked = 30
        wr(4, bcd(30));
        for (int mm = 0; mm < 60; mm++) begin
            set_now((mm % 2) * 5, mm, 7'h08, 1, 1);
            step(1, 0, 0, 0);
            chk(flag_b, (mm == 30), "R4 minute match");
            wr(8, 8'h00);
        end

        // R6/R8: mode 0 -> flag set, irq stays high
        wr(7, 8'h03);
        chk(irq_mode, 0, "R10 control mode bit");
        set_now(0, 30, 7'h08, 1, 1);
        step(1, 0, 0, 0);
        chk(flag_b, 1, "R6 flag in square-wave mode");
        chk(irq_n, 1, "R8 no irq in mode 0");
        // R8: switch to interrupt mode with flag B enabled
        wr(7, 8'h06);
        chk(irq_n, 0, "R8 irq asserted");
        // R7: writing 1 keeps the flag
        wr(8, 8'h03);
        chk(flag_b, 1, "R7 write 1 keeps"); chk(irq_n, 0, "R8 irq held");
        // R10: unmapped address write ignored
        wr(9, 8'h00); wr(15, 8'h00);
        chk(flag_b, 1, "R10 unmapped write"); chk(irq_n, 0, "R10 irq kept");
        // R7: clear only B (bit1=0, bit0=1)
        wr(8, 8'h01);
        chk(flag_b, 0, "R7 clear B"); chk(irq_n, 1, "R8 irq released");
        // R8: disabled flag A does not interrupt
        wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h80);
        set_now(7, 31, 7'h08, 1, 1);
        step(1, 0, 0, 0);
        chk(flag_a, 1, "R6 flag A set"); chk(irq_n, 1, "R8 enable A off");
        wr(7, 8'h05);
        chk(irq_n, 0, "R8 enable A on");
        // R7: set and clear in the same cycle -> set wins
        wr(8, 8'h00);
        chk(flag_a, 0, "R7 clear A");
        step(1, 1, 8, 8'h00);
        chk(flag_a, 1, "R7 set beats clear");

        // R9: reset again
        rst_n = 0; step(0, 0, 0, 0); rst_n = 1;
        chk(flag_a, 0, "R9 flags after reset"); chk(irq_n, 1, "R9 irq after reset");
        chk(irq_mode, 1, "R9 mode after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule